// File: doc/BRIEF.md
# Self-Checking Redundant Word Comparator

This block compares the result words of two redundant functional units and raises a single agreement flag. The comparison logic is built so that it also checks itself. Each bit holds two independent equality checkers. Each checker enables its own gated driver, and that driver places the opposite checker's verdict onto a shared per-bit net. An undriven net resolves low, as if a pull-down held it. As a result, a checker that wrongly reports disagreement can never be masked by the healthy one: the flag is high only when the operands agree and every checker is sound.

Each checker has a fault-injection mask bit that forces its verdict to "disagree". A test environment uses this to show that a checker fault is exposed. The per-bit verdicts are combined with an AND into one word-level flag. A parameter selects whether that flag is registered (one cycle of latency, synchronous active-low reset) or combinational.

Top module: `dm_mirror_cmp`

## Requirements
- R1: With OUT_REG=1, after a rising clock edge at which rst_n is 0, match_o is 0 whatever the operand and mask values are.
- R2: With no fault mask bit set, match_o is 1 when a_i equals b_i in every bit position.
- R3: If a_i and b_i differ in any one or more bit positions, match_o is 0, with or without injected faults.
- R4: Setting bit k of flt_a_i forces the first checker of bit k to report disagreement, and match_o is then 0 even when a_i equals b_i.
- R5: Setting bit k of flt_b_i forces the second checker of bit k to report disagreement, and match_o is then 0 even when a_i equals b_i.
- R6: If both checkers of the same bit are forced to disagree, their drivers release the net, it resolves low, and match_o is 0.
- R7: With OUT_REG=1, match_o is the verdict on the operands and masks sampled at the previous rising edge, so each new verdict replaces the previous one after exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered verdict |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | WIDTH | Result word from the first redundant unit |
| b_i | input | WIDTH | Result word from the second redundant unit |
| flt_a_i | input | WIDTH | Per-bit mask that forces the first checker to disagree |
| flt_b_i | input | WIDTH | Per-bit mask that forces the second checker to disagree |
| match_o | output | 1 | High only when the words agree and all checkers are healthy |

## Verification
In the default registered variant, every verdict is due one rising edge after its operands and masks are applied. The reset verdict is due at the first edge of reset. The bench applies stimulus right after a falling edge and computes the expected flag from the values present at the next rising edge. It then reads match_o at the following falling edge, which is half a period after that edge and clear of it. Operands and masks change every cycle in the alternating sequences, so a verdict that arrives one cycle early or late fails the comparison.

// File: rtl/dm_pkg.sv
package dm_pkg;

   // State of one gated driver attached to the shared per-bit net
   typedef struct packed {
      logic en;
      logic val;
   } dm_drv_t;

   // Resolution of the shared net: enabled drivers are wired-OR,
   // and an undriven net is pulled to 0
   function automatic logic dm_resolve(input dm_drv_t d0, input dm_drv_t d1);
      logic net;
      net = 1'b0;
      if (d0.en && d0.val) net = 1'b1;
      if (d1.en && d1.val) net = 1'b1;
      return net;
   endfunction

endpackage

// File: rtl/dm_checker.sv
module dm_checker (
   input  logic a,
   input  logic b,
   input  logic force_dis,
   output logic agree
);
   // Equality test; an injected fault pins the verdict at "disagree"
   always_comb agree = ~(a ^ b) & ~force_dis;
endmodule

// File: rtl/dm_driver.sv
module dm_driver
   import dm_pkg::*;
(
   input  logic    en,
   input  logic    val,
   output dm_drv_t drv
);
   always_comb begin
      drv.en  = en;
      drv.val = val;
   end
endmodule

// File: rtl/dm_bit_mirror.sv
module dm_bit_mirror
   import dm_pkg::*;
(
   input  logic a,
   input  logic b,
   input  logic flt_a,
   input  logic flt_b,
   output logic bit_match
);
   logic    chk_a, chk_b;
   dm_drv_t drv_a, drv_b;

   dm_checker u_chk_a (.a(a), .b(b), .force_dis(flt_a), .agree(chk_a));
   dm_checker u_chk_b (.a(a), .b(b), .force_dis(flt_b), .agree(chk_b));

   // Cross-coupled: each driver is enabled by its own checker and
   // carries the verdict of the other one
   dm_driver u_drv_a (.en(chk_a), .val(chk_b), .drv(drv_a));
   dm_driver u_drv_b (.en(chk_b), .val(chk_a), .drv(drv_b));

   always_comb bit_match = dm_resolve(drv_a, drv_b);
endmodule

// File: rtl/dm_mirror_cmp.sv
module dm_mirror_cmp #(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] flt_a_i,
   input  logic [WIDTH-1:0] flt_b_i,
   output logic             match_o
);
   localparam int LAST_BIT = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("dm_mirror_cmp: WIDTH must be at least 1");
   end

   logic [LAST_BIT:0] bit_match;
   logic              word_match;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      dm_bit_mirror u_mirror (
         .a        (a_i[i]),
         .b        (b_i[i]),
         .flt_a    (flt_a_i[i]),
         .flt_b    (flt_b_i[i]),
         .bit_match(bit_match[i])
      );
   end

   always_comb word_match = &bit_match;

   if (OUT_REG) begin : g_reg_out
      logic match_q;
      always_ff @(posedge clk) begin
         if (!rst_n) match_q <= 1'b0;
         else        match_q <= word_match;
      end
      assign match_o = match_q;
   end else begin : g_comb_out
      assign match_o = word_match;
   end
endmodule

// File: rtl/dm_mirror_cmp_chk.sv
module dm_mirror_cmp_chk #(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] flt_a_i,
   input logic [WIDTH-1:0] flt_b_i,
   input logic             match_o
);
   if (OUT_REG) begin : g_reg
      logic past_ok;
      logic in_rst_q;
      always_ff @(posedge clk) begin
         past_ok  <= rst_n;
         in_rst_q <= !rst_n;
      end

      // R1: reset clears the verdict
      always @(negedge clk) begin
         if (in_rst_q === 1'b1)
            p_reset_low_r1: assert (match_o == 1'b0);
      end

      // R2, R7: clean equal words give 1 one cycle later
      p_equal_high_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
         ($past(a_i) == $past(b_i) && $past(flt_a_i) == '0 && $past(flt_b_i) == '0) |-> match_o);
      // R3
      p_diff_low_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
         ($past(a_i) != $past(b_i)) |-> !match_o);
      // R4
      p_flt_a_low_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
         (|$past(flt_a_i)) |-> !match_o);
      // R5
      p_flt_b_low_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
         (|$past(flt_b_i)) |-> !match_o);
      // R6
      p_both_low_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
         (|($past(flt_a_i) & $past(flt_b_i))) |-> !match_o);
   end else begin : g_comb
      p_equal_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (a_i == b_i && flt_a_i == '0 && flt_b_i == '0) |-> match_o);
      p_diff_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (a_i != b_i) |-> !match_o);
      p_flt_a_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (|flt_a_i) |-> !match_o);
      p_flt_b_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (|flt_b_i) |-> !match_o);
   end
endmodule

bind dm_mirror_cmp dm_mirror_cmp_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
   .flt_a_i(flt_a_i), .flt_b_i(flt_b_i), .match_o(match_o)
);

// File: tb/dm_mirror_cmp_tb_top.sv
`timescale 1ns/1ps
module dm_mirror_cmp_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] a, b, fa, fb;
   logic         match_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   dm_mirror_cmp #(.WIDTH(W), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b),
      .flt_a_i(fa), .flt_b_i(fb), .match_o(match_o)
   );

   // Behavioural reference: one-cycle-delayed verdict
   function automatic logic ref_verdict(input logic r, input logic [W-1:0] x,
                                        input logic [W-1:0] y, input logic [W-1:0] f1,
                                        input logic [W-1:0] f2);
      if (!r) return 1'b0;
      return (x == y) && (f1 == 0) && (f2 == 0);
   endfunction

   task automatic cyc(input logic r, input logic [W-1:0] x, input logic [W-1:0] y,
                      input logic [W-1:0] f1, input logic [W-1:0] f2, input string req);
      logic exp;
      rst_n = r; a = x; b = y; fa = f1; fb = f2;
      @(posedge clk);
      exp = ref_verdict(r, x, y, f1, f2);
      @(negedge clk);
      checks++;
      if (match_o !== exp) begin
         failures++;
         $display("FAIL %s: a=%h b=%h fa=%h fb=%h match_o=%b expected=%b",
                  req, x, y, f1, f2, match_o, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0; a = '0; b = '0; fa = '0; fb = '0;
      @(negedge clk);
      // R1: reset holds the flag low even for clean equal words
      cyc(1'b0, 8'h3C, 8'h3C, 8'h00, 8'h00, "R1");
      cyc(1'b0, 8'hFF, 8'hFF, 8'h00, 8'h00, "R1");
      // R2: clean equal words
      cyc(1'b1, 8'h00, 8'h00, 8'h00, 8'h00, "R2");
      cyc(1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00, "R2");
      cyc(1'b1, 8'hA5, 8'hA5, 8'h00, 8'h00, "R2");
      cyc(1'b1, 8'h5A, 8'h5A, 8'h00, 8'h00, "R2");
      // R3: a single differing bit at each position, and full inversion
      for (int i = 0; i < W; i++) begin
         cyc(1'b1, 8'h96, 8'h96 ^ (8'h01 << i), 8'h00, 8'h00, "R3");
         cyc(1'b1, 8'h96, 8'h96, 8'h00, 8'h00, "R2");
      end
      cyc(1'b1, 8'h0F, 8'hF0, 8'h00, 8'h00, "R3");
      cyc(1'b1, 8'h0F, 8'hF1, 8'h01, 8'h00, "R3");
      // R4 / R5: one faulted checker per bit, operands equal
      for (int i = 0; i < W; i++) begin
         cyc(1'b1, 8'hC3, 8'hC3, 8'h01 << i, 8'h00, "R4");
         cyc(1'b1, 8'hC3, 8'hC3, 8'h00, 8'h00, "R2");
         cyc(1'b1, 8'h3C, 8'h3C, 8'h00, 8'h01 << i, "R5");
         cyc(1'b1, 8'h3C, 8'h3C, 8'h00, 8'h00, "R2");
      end
      // R6: both checkers of one bit faulted, and all faulted
      cyc(1'b1, 8'h77, 8'h77, 8'h10, 8'h10, "R6");
      cyc(1'b1, 8'h77, 8'h77, 8'hFF, 8'hFF, "R6");
      // R7: alternating verdicts every cycle expose wrong latency
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 8'h11 * i, 8'h11 * i, 8'h00, 8'h00, "R7");
         cyc(1'b1, 8'h11 * i, 8'h11 * i + 8'h01, 8'h00, 8'h00, "R7");
      end
      // R1: reset again mid-run
      cyc(1'b0, 8'h42, 8'h42, 8'h00, 8'h00, "R1");
      cyc(1'b1, 8'h42, 8'h42, 8'h00, 8'h00, "R2");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule